// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a serial peripheral interface master controlled through a 32-bit register port. Software programs a command register with the word length, the clock polarity and sampling edge, the chip-select routing and the transfer directions. It preloads up to four transmit words into a small FIFO. It then starts a block by writing a word count, together with a start bit, into the transfer-control register. The shift engine clocks out that many words, each most significant bit first. It samples the serial input into a receive FIFO, drives one of four chip selects, and raises a level interrupt when the block is done.

A block can run full duplex, transmit only or receive only. A receive-only block still generates the full clock train and shows the programmed idle level on the data output. The serial clock is a fixed division of the system clock, set by a parameter. Each idle line, clock and data, can be driven or left undriven (pulled) at either level. The ready flag and the two FIFO error flags are cleared by writing ones to them.

Top module: `ser_host_ctrl`

## Requirements
- R1: After reset the command and transfer-control registers read 0, and status reads 0x0280_0000 (only RX-empty bit 25 and TX-empty bit 23 set). Offsets: command 0x00, status 0x04, transfer control 0x0C, TX data write 0x10, RX data read 0x20.
- R2: Each FIFO holds 4 words. Status bit 22 is TX full and bit 24 is RX full. A write to 0x10 while the TX FIFO is full drops the data and sets TX overflow (status bit 26).
- R3: A read of 0x20 while the RX FIFO is empty returns 0 and sets RX underflow (status bit 27).
- R4: Writing 1 to status bit 30, 27 or 26 clears ready, RX underflow or TX overflow respectively. Writing 0 leaves them set.
- R5: A transfer-control write with bit 31 set starts a block of (bits 15:0)+1 words. While the block runs, status bit 31 (busy) and control bit 31 read 1. At the end both read 0 and ready (status bit 30) is set.
- R6: Each word is (command bits 4:0)+1 bits long and shifts most significant bit first. Received bits are right-justified in the RX entry. Command bit 26 gives the clock idle level. Command bit 21 = 0 samples MISO on the leading clock edge; bit 21 = 1 samples on the trailing edge.
- R7: With receive enabled (command bit 14) and transmit disabled (bit 15 = 0), the block still runs and stores every word. MOSI holds the idle data level (command bit 18) throughout.
- R8: If transmit is enabled and the TX FIFO is empty when a word is loaded, TX overflow is set and that word is sent as all zeros.
- R9: While idle, SCLK shows command bit 26 and MOSI shows bit 18. Command bit 27 (clock) or bit 19 (data) set to 1 releases the line: its output enable is 0.
- R10: Command bits 8:5 select CS0..CS3, and bit 16 sets the asserted level (0 means active low). Unselected pins show the inactive level. In hardware mode (bit 12 = 0) a selected pin is asserted only while busy. In software mode it shows bit 13 XOR bit 16.
- R11: irq_o is high while ready is set and either control bit 26 or bit 27 is set.
- R12: A start is ignored unless command bit 28 (master) is set.
- R13: Writes to the command and transfer-control registers are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| sclk_o | output | 1 | Serial clock level |
| sclk_oe_o | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out level |
| mosi_oe_o | output | 1 | Serial data out enable |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select pins |
| irq_o | output | 1 | Level interrupt |

## Verification
Register reads are combinational, so status and FIFO data are checked in the same cycle the address is applied. A write or a FIFO pop takes effect at the next clock edge, so its result is checked on the following access. A block lasts 2*HALF_DIV*(length) cycles per word. The bench does not assume that figure: it polls busy through the status register. It then checks ready, the interrupt, the cleared start bit and the received words once busy reads 0. Pin-level results (chip select, idle MOSI, idle line drive) are sampled at the negative clock edge after the write that sets them up, or in the middle of a running block.

// File: rtl/ser_host_pkg.sv
package ser_host_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h0C;
  localparam logic [7:0] OFS_TXD  = 8'h10;
  localparam logic [7:0] OFS_RXD  = 8'h20;

  localparam int C_CS_LO    = 5;
  localparam int C_SW_CS    = 12;
  localparam int C_CS_LVL   = 13;
  localparam int C_RX_EN    = 14;
  localparam int C_TX_EN    = 15;
  localparam int C_CS_INV   = 16;
  localparam int C_D_LVL    = 18;
  localparam int C_D_PULL   = 19;
  localparam int C_CPHA     = 21;
  localparam int C_K_LVL    = 26;
  localparam int C_K_PULL   = 27;
  localparam int C_MASTER   = 28;

  localparam int S_TXOVF    = 26;
  localparam int S_RXUNF    = 27;
  localparam int S_READY    = 30;

  localparam int T_IE_TX    = 26;
  localparam int T_IE_RX    = 27;
  localparam int T_GO       = 31;

  typedef struct packed {
    logic [4:0] len_m1;
    logic       cpol;
    logic       cpha;
    logic       tx_en;
    logic       rx_en;
  } eng_cfg_t;
endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= wdata_i;
        wp_q        <= nxt(wp_q);
      end
      if (do_pop) rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine
  import ser_host_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  eng_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] cnt_m1_i,
  input  logic             start_i,
  input  logic [31:0]      tx_data_i,
  input  logic             tx_empty_i,
  output logic             tx_pop_o,
  output logic             underrun_o,
  output logic             rx_push_o,
  output logic [31:0]      rx_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic             busy_q, sclk_q, seen_q;
  logic [DW-1:0]    div_q;
  logic [5:0]       edge_q;
  logic [4:0]       bidx_q;
  logic [CNT_W-1:0] word_q;
  logic [31:0]      txw_q, rx_q, rx_nxt;
  logic             tick, last_edge, smp, final_w, begin_blk, load;

  assign tick      = busy_q & (div_q == DW'(HALF_DIV - 1));
  assign last_edge = (edge_q == {cfg_i.len_m1, 1'b1});
  // even edge index = leading edge; sample edge depends on phase
  assign smp       = ~edge_q[0] ^ cfg_i.cpha;
  assign rx_nxt    = smp ? {rx_q[30:0], miso_i} : rx_q;
  assign final_w   = (word_q == cnt_m1_i);
  assign begin_blk = start_i & ~busy_q;
  assign load      = begin_blk | (tick & last_edge & ~final_w);

  assign tx_pop_o   = load & cfg_i.tx_en & ~tx_empty_i;
  assign underrun_o = load & cfg_i.tx_en & tx_empty_i;
  assign rx_push_o  = tick & last_edge & cfg_i.rx_en;
  assign rx_data_o  = rx_nxt;
  assign done_o     = tick & last_edge & final_w;
  assign busy_o     = busy_q;
  assign sclk_o     = sclk_q;
  assign mosi_o     = txw_q[bidx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      seen_q <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      bidx_q <= '0;
      word_q <= '0;
      txw_q  <= '0;
      rx_q   <= '0;
    end else begin
      if (begin_blk) begin
        busy_q <= 1'b1;
        word_q <= '0;
        sclk_q <= cfg_i.cpol;
      end
      if (busy_q) begin
        if (tick) begin
          div_q  <= '0;
          sclk_q <= ~sclk_q;
          if (last_edge) begin
            if (final_w) busy_q <= 1'b0;
            else         word_q <= word_q + 1'b1;
          end else begin
            edge_q <= edge_q + 1'b1;
            rx_q   <= rx_nxt;
            if (smp)                        seen_q <= 1'b1;
            else if (seen_q && bidx_q != 0) bidx_q <= bidx_q - 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
      if (load) begin
        txw_q  <= tx_pop_o ? tx_data_i : '0;
        edge_q <= '0;
        bidx_q <= cfg_i.len_m1;
        seen_q <= 1'b0;
        rx_q   <= '0;
        div_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/ser_host_ctrl.sv
module ser_host_ctrl
  import ser_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16,
  parameter int HALF_DIV   = 2,
  parameter int NUM_CS     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              irq_o
);
  logic [31:0] cmd_q;
  logic [30:0] ctrl_q;
  logic        ready_q, txovf_q, rxunf_q;
  logic        wr, rd, wr_cmd, wr_ctrl, wr_stat, wr_tx, rd_rx, start;
  logic        tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;
  logic [31:0] tx_head, rx_head, rx_word;
  logic        busy, done, underrun, eng_sclk, eng_mosi, drive_d;
  eng_cfg_t    cfg;

  assign wr      = bus_sel_i & bus_we_i;
  assign rd      = bus_sel_i & ~bus_we_i;
  assign wr_cmd  = wr & (bus_addr_i == OFS_CMD)  & ~busy;
  assign wr_ctrl = wr & (bus_addr_i == OFS_CTRL) & ~busy;
  assign wr_stat = wr & (bus_addr_i == OFS_STAT);
  assign wr_tx   = wr & (bus_addr_i == OFS_TXD);
  assign rd_rx   = rd & (bus_addr_i == OFS_RXD);
  assign start   = wr_ctrl & bus_wdata_i[T_GO] & cmd_q[C_MASTER];

  assign cfg = '{len_m1: cmd_q[4:0], cpol: cmd_q[C_K_LVL], cpha: cmd_q[C_CPHA],
                 tx_en: cmd_q[C_TX_EN], rx_en: cmd_q[C_RX_EN]};

  ser_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i, .rst_ni, .push_i(wr_tx), .wdata_i(bus_wdata_i), .pop_i(tx_pop),
    .rdata_o(tx_head), .full_o(tx_full), .empty_o(tx_empty));

  ser_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i, .rst_ni, .push_i(rx_push), .wdata_i(rx_word), .pop_i(rd_rx),
    .rdata_o(rx_head), .full_o(rx_full), .empty_o(rx_empty));

  ser_shift_engine #(.CNT_W(CNT_W), .HALF_DIV(HALF_DIV)) u_eng (
    .clk_i, .rst_ni, .cfg_i(cfg), .cnt_m1_i(ctrl_q[CNT_W-1:0]), .start_i(start),
    .tx_data_i(tx_head), .tx_empty_i(tx_empty), .tx_pop_o(tx_pop),
    .underrun_o(underrun), .rx_push_o(rx_push), .rx_data_o(rx_word),
    .busy_o(busy), .done_o(done), .sclk_o(eng_sclk), .mosi_o(eng_mosi),
    .miso_i(miso_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      ctrl_q  <= '0;
      ready_q <= 1'b0;
      txovf_q <= 1'b0;
      rxunf_q <= 1'b0;
    end else begin
      if (wr_cmd)  cmd_q  <= bus_wdata_i;
      if (wr_ctrl) ctrl_q <= bus_wdata_i[30:0];
      if (wr_stat) begin
        if (bus_wdata_i[S_READY]) ready_q <= 1'b0;
        if (bus_wdata_i[S_TXOVF]) txovf_q <= 1'b0;
        if (bus_wdata_i[S_RXUNF]) rxunf_q <= 1'b0;
      end
      // set wins over a same-cycle clear
      if (done)                            ready_q <= 1'b1;
      if ((wr_tx && tx_full) || underrun)  txovf_q <= 1'b1;
      if (rd_rx && rx_empty)               rxunf_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_CMD:  bus_rdata_o = cmd_q;
      OFS_STAT: bus_rdata_o = {busy, ready_q, 2'b00, rxunf_q, txovf_q,
                               rx_empty, rx_full, tx_empty, tx_full, 22'd0};
      OFS_CTRL: bus_rdata_o = {busy, ctrl_q};
      OFS_RXD:  bus_rdata_o = rx_empty ? '0 : rx_head;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o     = ready_q & (ctrl_q[T_IE_TX] | ctrl_q[T_IE_RX]);
  assign sclk_o    = busy ? eng_sclk : cmd_q[C_K_LVL];
  assign sclk_oe_o = busy | ~cmd_q[C_K_PULL];
  assign drive_d   = busy & cmd_q[C_TX_EN];
  assign mosi_o    = drive_d ? eng_mosi : cmd_q[C_D_LVL];
  assign mosi_oe_o = drive_d | ~cmd_q[C_D_PULL];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    logic act;
    assign act = cmd_q[C_SW_CS] ? ~cmd_q[C_CS_LVL] : busy;
    assign cs_o[g] = (cmd_q[C_CS_LO + g] & act) ? cmd_q[C_CS_INV] : ~cmd_q[C_CS_INV];
  end
endmodule

// File: rtl/ser_host_chk.sv
module ser_host_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_tx,
  input logic       rd_rx,
  input logic       tx_full,
  input logic       rx_empty,
  input logic       txovf,
  input logic       rxunf,
  input logic       busy,
  input logic       ready,
  input logic       sw_cs,
  input logic       inv,
  input logic [3:0] cs_o,
  input logic       tx_en,
  input logic       mosi_o,
  input logic       go_wr
);
  a_r2_ovf_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx && tx_full |=> txovf);
  a_r3_unf_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rx && rx_empty |=> rxunf);
  a_r5_ready_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> ready);
  a_r7_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) && !tx_en |-> $stable(mosi_o));
  a_r10_cs_hw_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !sw_cs |-> cs_o == {4{~inv}});
  a_r13_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && go_wr |=> busy || ready);
endmodule

bind ser_host_ctrl ser_host_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_tx(wr_tx), .rd_rx(rd_rx),
  .tx_full(tx_full), .rx_empty(rx_empty), .txovf(txovf_q), .rxunf(rxunf_q),
  .busy(busy), .ready(ready_q), .sw_cs(cmd_q[12]), .inv(cmd_q[16]),
  .cs_o(cs_o), .tx_en(cmd_q[15]), .mosi_o(mosi_o),
  .go_wr(wr & (bus_addr_i == 8'h0C)));

// File: tb/ser_host_ctrl_tb.sv
`timescale 1ns/1ps
module ser_host_ctrl_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, sclk_oe, mosi, mosi_oe, irq, loopback = 1'b1, miso_k = 1'b0;
  logic [3:0]  cs;
  int          checks = 0, fails = 0;
  bit          done_flag = 1'b0;

  always #2 clk = ~clk;

  ser_host_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sclk_o(sclk), .sclk_oe_o(sclk_oe), .mosi_o(mosi), .mosi_oe_o(mosi_oe),
    .miso_i(loopback ? mosi : miso_k), .cs_o(cs), .irq_o(irq));

  localparam logic [31:0] MST = 32'h1000_0000, CS0 = 32'h20, TXE = 32'h8000, RXE = 32'h4000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a; #0.5 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  function automatic logic [31:0] msk(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h04, s);
      if (!s[31]) break;
    end
  endtask

  // full block with loopback; returns nothing, checks inside
  task automatic run_block(input string tag, input int len, input bit cpol, input bit cpha,
                           input int nw, input logic [31:0] d0, input logic [31:0] d1,
                           input logic [31:0] d2, input logic [31:0] d3);
    logic [31:0] dat [4];
    logic [31:0] r;
    dat[0] = d0; dat[1] = d1; dat[2] = d2; dat[3] = d3;
    loopback = 1;
    wr(8'h00, MST | CS0 | TXE | RXE | (32'(cpol) << 26) | (32'(cpha) << 21) | 32'(len - 1));
    for (int i = 0; i < nw; i++) wr(8'h10, dat[i]);
    wr(8'h0C, 32'h8400_0000 | 32'(nw - 1));
    rd(8'h0C, r);  chk({tag, " R5 go reads 1 while busy"}, r[31], 1'b1);
    chk({tag, " R10 cs0 asserted in block"}, {28'd0, cs}, 32'hE);
    wait_idle();
    rd(8'h04, r);  chk({tag, " R5 ready set busy clear"}, r[31:30], 2'b01);
    chk({tag, " R11 irq with ie"}, {31'd0, irq}, 32'd1);
    rd(8'h0C, r);  chk({tag, " R5 go bit cleared"}, r[31], 1'b0);
    chk({tag, " R9 sclk idle level"}, {31'd0, sclk}, 32'(cpol));
    for (int i = 0; i < nw; i++) begin
      rd(8'h20, r); chk({tag, " R6 rx word"}, r, dat[i] & msk(len));
    end
    wr(8'h04, 32'h4C00_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_0001));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, r); chk("R1 cmd reset", r, 32'h0);
    rd(8'h0C, r); chk("R1 ctrl reset", r, 32'h0);
    rd(8'h04, r); chk("R1 status reset", r, 32'h0280_0000);
    chk("R11 irq low after reset", {31'd0, irq}, 32'd0);
    chk("R10 cs inactive after reset", {28'd0, cs}, 32'hF);

    // R3 underflow
    rd(8'h20, r); chk("R3 empty read returns 0", r, 32'h0);
    rd(8'h04, r); chk("R3 underflow flag", r[27], 1'b1);
    // R2 overflow
    for (int i = 0; i < 4; i++) wr(8'h10, 32'hA0 + 32'(i));
    rd(8'h04, r); chk("R2 tx full flag", r[22], 1'b1);
    chk("R2 no overflow yet", r[26], 1'b0);
    wr(8'h10, 32'hDEAD);
    rd(8'h04, r); chk("R2 overflow flag", r[26], 1'b1);
    // R4 write 0 keeps, write 1 clears
    wr(8'h04, 32'h0);
    rd(8'h04, r); chk("R4 write 0 keeps flags", {30'd0, r[27:26]}, 32'h3);
    wr(8'h04, 32'h0C00_0000);
    rd(8'h04, r); chk("R4 w1c clears flags", {30'd0, r[27:26]}, 32'h0);

    // drain via 4-word 8-bit block; checks dropped 5th word never shows
    wr(8'h00, MST | CS0 | TXE | RXE | 32'd7);
    wr(8'h0C, 32'h8000_0003);
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      rd(8'h20, r); chk("R2 kept words in order", r, 32'hA0 + 32'(i));
    end
    rd(8'h04, r); chk("R11 ready without ie", r[30], 1'b1);
    chk("R11 irq low without ie", {31'd0, irq}, 32'd0);
    wr(8'h04, 32'h4000_0000);

    // directed corner cases of R6
    run_block("len32", 32, 1'b0, 1'b0, 4, 32'h8000_0001, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0);
    run_block("len1",  1,  1'b1, 1'b1, 2, 32'h1, 32'h0, 32'h0, 32'h0);
    // random mix
    for (int t = 0; t < 12; t++) begin
      int ln = 1 + int'($urandom_range(0, 31));
      run_block("rand", ln, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1 + int'($urandom_range(0, 3)), $urandom, $urandom, $urandom, $urandom);
    end

    // R7 rx-only, idle data high, miso held 1
    loopback = 0; miso_k = 1;
    wr(8'h00, MST | CS0 | RXE | 32'h0004_0000 | 32'd11);
    wr(8'h0C, 32'h8000_0001);
    repeat (10) @(negedge clk);
    chk("R7 mosi idle level mid-block", {31'd0, mosi}, 32'd1);
    wait_idle();
    rd(8'h20, r); chk("R7 rx-only word0", r, 32'hFFF);
    rd(8'h20, r); chk("R7 rx-only word1", r, 32'hFFF);
    rd(8'h04, r); chk("R7 no tx error", r[26], 1'b0);
    wr(8'h04, 32'h4000_0000);

    // R8 tx runs dry
    loopback = 1;
    wr(8'h00, MST | CS0 | TXE | RXE | 32'd7);
    wr(8'h10, 32'h5A);
    wr(8'h0C, 32'h8000_0001);
    wait_idle();
    rd(8'h04, r); chk("R8 dry tx sets overflow", r[26], 1'b1);
    rd(8'h20, r); chk("R8 first word sent", r, 32'h5A);
    rd(8'h20, r); chk("R8 dry word is zero", r, 32'h0);
    wr(8'h04, 32'h4C00_0000);

    // R13 writes ignored while busy
    wr(8'h00, MST | CS0 | TXE | RXE | 32'd15);
    wr(8'h10, 32'h1); wr(8'h10, 32'h2);
    wr(8'h0C, 32'h8000_0001);
    wr(8'h00, 32'h0);
    wr(8'h0C, 32'h8800_0003);
    wait_idle();
    rd(8'h00, r); chk("R13 cmd unchanged by busy write", r, MST | CS0 | TXE | RXE | 32'd15);
    rd(8'h0C, r); chk("R13 ctrl unchanged by busy write", r, 32'h0000_0001);
    rd(8'h20, r); rd(8'h20, r); chk("R13 second word", r, 32'h2);
    wr(8'h04, 32'h4C00_0000);

    // R12 master bit clear
    wr(8'h00, CS0 | TXE);
    wr(8'h0C, 32'h8000_0000);
    rd(8'h04, r); chk("R12 no start without master", r[31], 1'b0);
    rd(8'h0C, r); chk("R12 go bit stays 0", r[31], 1'b0);

    // R9 idle drive codes
    wr(8'h00, 32'h0400_0000);
    chk("R9 sclk drive high", {30'd0, sclk, sclk_oe}, 32'h3);
    wr(8'h00, 32'h0808_0000);
    chk("R9 sclk/mosi pull low", {28'd0, sclk, sclk_oe, mosi, mosi_oe}, 32'h0);
    wr(8'h00, 32'h0004_0000);
    chk("R9 mosi drive high", {30'd0, mosi, mosi_oe}, 32'h3);

    // R10 software chip select
    wr(8'h00, MST | 32'h1000 | 32'h80);
    chk("R10 sw cs2 asserted", {28'd0, cs}, 32'hB);
    wr(8'h00, MST | 32'h1000 | 32'h2000 | 32'h80);
    chk("R10 sw cs2 level high", {28'd0, cs}, 32'hF);
    wr(8'h00, MST | 32'h1_0000 | 32'h1000 | 32'h80);
    chk("R10 sw cs2 inverted", {28'd0, cs}, 32'h4);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule